// File: doc/BRIEF.md
# Translation Lookup with Address-Space Rings and Access Rights

This block is the lookup half of a set-associative address translation buffer, built for either the instruction-fetch side or the load/store side, chosen by a parameter. A request carries a virtual address, a load/store flag and the current privilege index. Each way is indexed by low virtual-page bits and returns one entry. An entry counts as a hit only if all three of these hold: its page matches, its address-space identifier is nonzero, and that identifier appears in a 32-bit ring register. The byte that matches gives the entry's privilege ring. One cycle after the request, the block returns either a physical address with a cache-mode code, or an exception cause.

There are two kinds of way. The variable ways use small pages and are filled by software through a write port. Two fixed ways use large pages and are preloaded at reset with a window of uncached and cached mappings. Software may later rewrite them through the same port. Page-table refill and the cache itself sit outside this block.

Top module: `tlb_lookup_unit`

## Requirements
- R1: After reset, the ring register holds 0x04030201 and every variable-way entry has identifier 0. The first fixed way (way 4) maps 0xD0000000 to 0x00000000 with attribute 7, and 0xD8000000 to 0x00000000 with attribute 3. The second fixed way (way 5) maps 0xE0000000 to 0xF0000000 with attribute 7, and 0xF0000000 to 0xF0000000 with attribute 3. All four preloaded entries use identifier 1.
- R2: An entry's identifier is compared with the four bytes of the ring register. Byte i (bits 8i+7..8i) gives ring i, and the lowest matching byte wins. An entry whose identifier matches no byte never hits. ring_we loads ring_wdata into the register.
- R3: An entry hits when its stored page equals the page of req_va and its identifier is nonzero. Variable ways (0..3) use 4 KB pages, with index req_va[13:12]. The fixed ways use 128 MB pages. Way 4 is indexed by req_va[27] and way 5 by req_va[28].
- R4: When no way hits, rsp_cause is 1 on the fetch side and 2 on the data side.
- R5: When two or more ways hit, rsp_cause is 3 on the fetch side and 4 on the data side. This takes precedence over every other cause.
- R6: When exactly one way hits and its ring is below req_priv, rsp_cause is 5 on the fetch side and 6 on the data side.
- R7: Attribute decoding works as follows. An attribute below 12 grants read; in that case bit 0 grants execute, bit 1 grants write, and bits [3:2] give rsp_cache (0 bypass, 1 write-back, 2 write-through). Attribute 13 grants read and write with rsp_cache 3 (isolate). Attributes 12, 14 and 15 grant nothing.
- R8: The data side ignores execute rights and the fetch side ignores read and write rights. A denied access gives rsp_cause 7 for a fetch, 8 for a load and 9 for a store (req_store=1).
- R9: A successful lookup gives rsp_cause 0 and rsp_pa equal to the entry's physical page ORed with the page-offset bits of req_va. On any fault, rsp_pa and rsp_cache are 0.
- R10: rsp_valid is high exactly in the cycle after each cycle with req_valid high, and the response fields load only then. A write or ring update in the same cycle as a lookup is not visible to that lookup; it takes effect for the next one.
- R11: wr_en writes wr_va and wr_pa, both cut to the way's page, together with wr_asid and wr_attr, into entry wr_idx of way wr_way. For the fixed ways only wr_idx[0] is used. A wr_way value of 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address to translate |
| req_store | input | 1 | Data side: 1 store, 0 load |
| req_priv | input | 2 | Current privilege index (0 most privileged) |
| ring_we | input | 1 | Load ring register |
| ring_wdata | input | 32 | New ring register value |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 3 | Way to write |
| wr_idx | input | 2 | Entry index within the way |
| wr_va | input | 32 | Virtual page for the entry |
| wr_pa | input | 32 | Physical page for the entry |
| wr_asid | input | 8 | Address-space identifier |
| wr_attr | input | 4 | Access and cache attribute |
| rsp_valid | output | 1 | Response present |
| rsp_cause | output | 4 | 0 success, otherwise exception code |
| rsp_pa | output | 32 | Translated physical address |
| rsp_cache | output | 2 | Cache mode of the hit |

## Verification
The assertions check the following on every cycle. The response valid follows the request by one cycle. Faults zero the address and cache fields. A successful translation keeps the low 12 address bits. The side never reports the other side's cause codes. The ring register comes out of reset with its preset value. The bench scenarios are the only place the following can be shown: the actual selection of causes (multi-hit over miss, ring against privilege), the full 16-value attribute decode on both sides, the lowest-byte ring rule, ignored out-of-range writes, and lookups that race with a write.

// File: rtl/tlb_pkg.sv
// Shared types for the translation lookup block.
// Assumes: 32-bit addresses, 8-bit identifiers, 4-bit attributes.
package tlb_pkg;

    typedef enum logic [3:0] {
        CAUSE_NONE        = 4'd0,
        CAUSE_MISS_FETCH  = 4'd1,
        CAUSE_MISS_DATA   = 4'd2,
        CAUSE_MULTI_FETCH = 4'd3,
        CAUSE_MULTI_DATA  = 4'd4,
        CAUSE_PRIV_FETCH  = 4'd5,
        CAUSE_PRIV_DATA   = 4'd6,
        CAUSE_DENY_FETCH  = 4'd7,
        CAUSE_DENY_LOAD   = 4'd8,
        CAUSE_DENY_STORE  = 4'd9
    } cause_e;

    typedef enum logic [1:0] {
        CM_BYPASS  = 2'd0,
        CM_WBACK   = 2'd1,
        CM_WTHRU   = 2'd2,
        CM_ISOLATE = 2'd3
    } cache_e;

    typedef struct packed {
        logic   rd;
        logic   wr;
        logic   ex;
        cache_e cm;
    } perm_t;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] pa;
        logic [7:0]  asid;
        logic [3:0]  attr;
    } entry_t;

    localparam logic [31:0] RING_RESET = 32'h0403_0201;

endpackage

// File: rtl/tlb_ring_map.sv
// Maps an address-space identifier to a ring by searching the four
// bytes of the ring register; the lowest matching byte wins.
// Assumes: caller separately qualifies identifier zero.
module tlb_ring_map (
    input  logic [31:0] ring_ids,
    input  logic [7:0]  asid,
    output logic        found,
    output logic [1:0]  ring
);
    // Search from the top byte down so the lowest match is kept last.
    always_comb begin
        found = 1'b0;
        ring  = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (ring_ids[8*i +: 8] == asid) begin
                found = 1'b1;
                ring  = 2'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_attr_decode.sv
// Decodes a 4-bit entry attribute into read/write/execute rights and a
// cache-mode code. Assumes: no side masking here; the top applies it.
module tlb_attr_decode
    import tlb_pkg::*;
(
    input  logic [3:0] attr,
    output perm_t      perm
);
    // Rights and cache mode per attribute value.
    always_comb begin
        perm = '0;
        if (attr < 4'd12) begin
            perm.rd = 1'b1;
            perm.ex = attr[0];
            perm.wr = attr[1];
            perm.cm = cache_e'(attr[3:2]);
        end else if (attr == 4'd13) begin
            perm.rd = 1'b1;
            perm.wr = 1'b1;
            perm.cm = CM_ISOLATE;
        end
    end
endmodule

// File: rtl/tlb_way_bank.sv
// One way of the translation buffer: ENTRIES entries with a fixed page
// size, indexed by the address bits starting at IDX_LSB. Provides the
// indexed entry and its page match for a lookup address, and takes
// writes. Fixed ways load two preset entries at reset.
// Assumes: ENTRIES is a power of two, at least 2.
module tlb_way_bank
    import tlb_pkg::*;
#(
    parameter int          ENTRIES   = 4,
    parameter int          PAGE_BITS = 12,
    parameter int          IDX_LSB   = 12,
    parameter bit          FIXED     = 1'b0,
    parameter logic [31:0] RST_VA0   = 32'h0,
    parameter logic [31:0] RST_PA0   = 32'h0,
    parameter logic [3:0]  RST_ATTR0 = 4'h0,
    parameter logic [31:0] RST_VA1   = 32'h0,
    parameter logic [31:0] RST_PA1   = 32'h0,
    parameter logic [3:0]  RST_ATTR1 = 4'h0,
    parameter logic [7:0]  RST_ASID  = 8'h0,
    localparam int         IW        = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_va,
    input  logic [31:0]   wr_pa,
    input  logic [7:0]    wr_asid,
    input  logic [3:0]    wr_attr,
    input  logic [31:0]   lk_va,
    output entry_t        lk_entry,
    output logic          lk_page_match
);
    localparam logic [31:0] PMASK = ~((32'd1 << PAGE_BITS) - 32'd1);

    entry_t        mem [ENTRIES];
    logic [IW-1:0] lk_idx;

    function automatic entry_t reset_entry(int e);
        entry_t r;
        r = '0;
        if (FIXED) begin
            if (e == 0)
                r = '{va: RST_VA0 & PMASK, pa: RST_PA0 & PMASK, asid: RST_ASID, attr: RST_ATTR0};
            else if (e == 1)
                r = '{va: RST_VA1 & PMASK, pa: RST_PA1 & PMASK, asid: RST_ASID, attr: RST_ATTR1};
        end
        return r;
    endfunction

    // Entry storage: preset on reset, otherwise written by the fill port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                mem[e] <= reset_entry(e);
            end
        end else if (wr_en) begin
            mem[wr_idx] <= '{va: wr_va & PMASK, pa: wr_pa & PMASK, asid: wr_asid, attr: wr_attr};
        end
    end

    assign lk_idx        = lk_va[IDX_LSB +: IW];
    assign lk_entry      = mem[lk_idx];
    assign lk_page_match = (mem[lk_idx].va == (lk_va & PMASK));
endmodule

// File: rtl/tlb_lookup_unit.sv
// Translation lookup top: variable small-page ways plus two fixed
// large-page ways, ring register, hit/multi-hit detection, privilege and
// rights check, registered response one cycle after each request.
// Assumes: VAR_ENTRIES is a power of two >= 2; fixed ways hold 2 entries.
module tlb_lookup_unit
    import tlb_pkg::*;
#(
    parameter int  NUM_VAR_WAYS  = 4,
    parameter int  VAR_ENTRIES   = 4,
    parameter int  VAR_PAGE_BITS = 12,
    parameter int  FIX_PAGE_BITS = 27,
    parameter int  FIXA_IDX_BIT  = 27,
    parameter int  FIXB_IDX_BIT  = 28,
    parameter bit  DATA_SIDE     = 1'b1,
    localparam int NUM_WAYS      = NUM_VAR_WAYS + 2,
    localparam int WAY_W         = $clog2(NUM_WAYS),
    localparam int VIW           = $clog2(VAR_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_va,
    input  logic             req_store,
    input  logic [1:0]       req_priv,
    input  logic             ring_we,
    input  logic [31:0]      ring_wdata,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [VIW-1:0]   wr_idx,
    input  logic [31:0]      wr_va,
    input  logic [31:0]      wr_pa,
    input  logic [7:0]       wr_asid,
    input  logic [3:0]       wr_attr,
    output logic             rsp_valid,
    output logic [3:0]       rsp_cause,
    output logic [31:0]      rsp_pa,
    output logic [1:0]       rsp_cache
);
    localparam logic [31:0] PMASK_V = ~((32'd1 << VAR_PAGE_BITS) - 32'd1);
    localparam logic [31:0] PMASK_F = ~((32'd1 << FIX_PAGE_BITS) - 32'd1);

    logic [31:0]         ring_q;
    logic [NUM_WAYS-1:0] way_hit;
    entry_t              way_ent  [NUM_WAYS];
    logic [1:0]          way_ring [NUM_WAYS];

    entry_t      sel_ent;
    logic [1:0]  sel_ring;
    logic        sel_fixed;
    logic [WAY_W:0] hit_cnt;
    perm_t       perm;
    logic        grant;
    cause_e      cause_c;
    logic [31:0] pa_c;

    // Ring register: preset on reset, loaded by ring_we.
    always_ff @(posedge clk) begin
        if (!rst_n)       ring_q <= RING_RESET;
        else if (ring_we) ring_q <= ring_wdata;
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic       we;
        entry_t     ent;
        logic       pmatch;
        logic       rfound;
        logic [1:0] rring;

        assign we = wr_en && (wr_way == WAY_W'(w));

        if (w < NUM_VAR_WAYS) begin : g_var
            tlb_way_bank #(
                .ENTRIES   (VAR_ENTRIES),
                .PAGE_BITS (VAR_PAGE_BITS),
                .IDX_LSB   (VAR_PAGE_BITS),
                .FIXED     (1'b0)
            ) u_bank (
                .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_idx(wr_idx),
                .wr_va(wr_va), .wr_pa(wr_pa), .wr_asid(wr_asid), .wr_attr(wr_attr),
                .lk_va(req_va), .lk_entry(ent), .lk_page_match(pmatch)
            );
        end else begin : g_fix
            localparam bit SECOND = (w == NUM_VAR_WAYS + 1);
            tlb_way_bank #(
                .ENTRIES   (2),
                .PAGE_BITS (FIX_PAGE_BITS),
                .IDX_LSB   (SECOND ? FIXB_IDX_BIT : FIXA_IDX_BIT),
                .FIXED     (1'b1),
                .RST_VA0   (SECOND ? 32'hE000_0000 : 32'hD000_0000),
                .RST_PA0   (SECOND ? 32'hF000_0000 : 32'h0000_0000),
                .RST_ATTR0 (4'd7),
                .RST_VA1   (SECOND ? 32'hF000_0000 : 32'hD800_0000),
                .RST_PA1   (SECOND ? 32'hF000_0000 : 32'h0000_0000),
                .RST_ATTR1 (4'd3),
                .RST_ASID  (8'd1)
            ) u_bank (
                .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_idx(wr_idx[0]),
                .wr_va(wr_va), .wr_pa(wr_pa), .wr_asid(wr_asid), .wr_attr(wr_attr),
                .lk_va(req_va), .lk_entry(ent), .lk_page_match(pmatch)
            );
        end

        tlb_ring_map u_ring (
            .ring_ids (ring_q),
            .asid     (ent.asid),
            .found    (rfound),
            .ring     (rring)
        );

        assign way_hit[w]  = pmatch && (ent.asid != 8'd0) && rfound;
        assign way_ent[w]  = ent;
        assign way_ring[w] = rring;
    end

    // Pick the lowest-numbered hitting way and note its page size.
    always_comb begin
        sel_ent   = '0;
        sel_ring  = 2'd0;
        sel_fixed = 1'b0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                sel_ent   = way_ent[w];
                sel_ring  = way_ring[w];
                sel_fixed = (w >= NUM_VAR_WAYS);
            end
        end
    end

    assign hit_cnt = (WAY_W+1)'($countones(way_hit));

    tlb_attr_decode u_attr (
        .attr (sel_ent.attr),
        .perm (perm)
    );

    // Side masking: data uses read/write, fetch uses execute only.
    assign grant = DATA_SIDE ? (req_store ? perm.wr : perm.rd) : perm.ex;
    assign pa_c  = sel_ent.pa | (req_va & ~(sel_fixed ? PMASK_F : PMASK_V));

    // Cause priority: multi-hit, miss, privilege, rights.
    always_comb begin
        if (hit_cnt > (WAY_W+1)'(1))
            cause_c = DATA_SIDE ? CAUSE_MULTI_DATA : CAUSE_MULTI_FETCH;
        else if (hit_cnt == '0)
            cause_c = DATA_SIDE ? CAUSE_MISS_DATA : CAUSE_MISS_FETCH;
        else if (sel_ring < req_priv)
            cause_c = DATA_SIDE ? CAUSE_PRIV_DATA : CAUSE_PRIV_FETCH;
        else if (!grant)
            cause_c = DATA_SIDE ? (req_store ? CAUSE_DENY_STORE : CAUSE_DENY_LOAD)
                                : CAUSE_DENY_FETCH;
        else
            cause_c = CAUSE_NONE;
    end

    // Response register: loaded one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_cause <= 4'd0;
            rsp_pa    <= 32'd0;
            rsp_cache <= 2'd0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_cause <= 4'(cause_c);
                rsp_pa    <= (cause_c == CAUSE_NONE) ? pa_c : 32'd0;
                rsp_cache <= (cause_c == CAUSE_NONE) ? 2'(perm.cm) : 2'd0;
            end
        end
    end
endmodule

// File: rtl/tlb_lookup_unit_chk.sv
// Property checker for tlb_lookup_unit, attached by bind.
// Assumes: the smallest page is MIN_PAGE_BITS wide.
module tlb_lookup_unit_chk #(
    parameter bit DATA_SIDE     = 1'b1,
    parameter int MIN_PAGE_BITS = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_va,
    input logic        rsp_valid,
    input logic [3:0]  rsp_cause,
    input logic [31:0] rsp_pa,
    input logic [1:0]  rsp_cache,
    input logic [31:0] ring_q
);
    p_rsp_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_fault_zeroes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != 4'd0) |-> (rsp_pa == 32'd0 && rsp_cache == 2'd0));

    p_offset_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == 4'd0) |->
            (rsp_pa[MIN_PAGE_BITS-1:0] == $past(req_va[MIN_PAGE_BITS-1:0])));

    p_side_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (DATA_SIDE ?
            (rsp_cause inside {4'd0, 4'd2, 4'd4, 4'd6, 4'd8, 4'd9}) :
            (rsp_cause inside {4'd0, 4'd1, 4'd3, 4'd5, 4'd7})));

    p_ring_preset_r1: assert property (@(posedge clk)
        !rst_n |=> (ring_q == 32'h0403_0201));

    p_isolate_data_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == 4'd0 && rsp_cache == 2'd3) |-> DATA_SIDE);
endmodule

bind tlb_lookup_unit tlb_lookup_unit_chk #(
    .DATA_SIDE     (DATA_SIDE),
    .MIN_PAGE_BITS (VAR_PAGE_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_pa(rsp_pa),
    .rsp_cache(rsp_cache), .ring_q(ring_q)
);

// File: tb/tlb_lookup_unit_test.sv
`timescale 1ns/1ps
module tlb_lookup_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_store = 1'b0;
    logic [1:0]  req_priv = '0;
    logic        ring_we = 1'b0;
    logic [31:0] ring_wdata = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_way = '0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_va = '0, wr_pa = '0;
    logic [7:0]  wr_asid = '0;
    logic [3:0]  wr_attr = '0;

    logic        d_valid, f_valid;
    logic [3:0]  d_cause, f_cause;
    logic [31:0] d_pa, f_pa;
    logic [1:0]  d_cache, f_cache;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    tlb_lookup_unit #(.DATA_SIDE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_store(req_store), .req_priv(req_priv), .ring_we(ring_we),
        .ring_wdata(ring_wdata), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
        .wr_va(wr_va), .wr_pa(wr_pa), .wr_asid(wr_asid), .wr_attr(wr_attr),
        .rsp_valid(d_valid), .rsp_cause(d_cause), .rsp_pa(d_pa), .rsp_cache(d_cache));

    tlb_lookup_unit #(.DATA_SIDE(1'b0)) uut_fetch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_store(req_store), .req_priv(req_priv), .ring_we(ring_we),
        .ring_wdata(ring_wdata), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
        .wr_va(wr_va), .wr_pa(wr_pa), .wr_asid(wr_asid), .wr_attr(wr_attr),
        .rsp_valid(f_valid), .rsp_cause(f_cause), .rsp_pa(f_pa), .rsp_cache(f_cache));

    // Behavioural reference state
    logic [31:0] m_va   [6][4];
    logic [31:0] m_pa   [6][4];
    logic [7:0]  m_asid [6][4];
    logic [3:0]  m_attr [6][4];
    logic [31:0] m_ring;

    function automatic int page_bits(int w);
        return (w < 4) ? 12 : 27;
    endfunction

    function automatic int way_index(int w, logic [31:0] va);
        if (w < 4)  return int'(va[13:12]);
        if (w == 4) return int'(va[27]);
        return int'(va[28]);
    endfunction

    task automatic model_reset();
        for (int w = 0; w < 6; w++)
            for (int e = 0; e < 4; e++) begin
                m_va[w][e] = 0; m_pa[w][e] = 0; m_asid[w][e] = 0; m_attr[w][e] = 0;
            end
        m_va[4][0] = 32'hD000_0000; m_pa[4][0] = 32'h0;         m_attr[4][0] = 7; m_asid[4][0] = 1;
        m_va[4][1] = 32'hD800_0000; m_pa[4][1] = 32'h0;         m_attr[4][1] = 3; m_asid[4][1] = 1;
        m_va[5][0] = 32'hE000_0000; m_pa[5][0] = 32'hF000_0000; m_attr[5][0] = 7; m_asid[5][0] = 1;
        m_va[5][1] = 32'hF000_0000; m_pa[5][1] = 32'hF000_0000; m_attr[5][1] = 3; m_asid[5][1] = 1;
        m_ring = 32'h0403_0201;
    endtask

    // Expected outcome of one lookup from the requirement rules.
    task automatic ref_lookup(input bit dside, input logic [31:0] va, input bit st,
                              input int priv, output int cause,
                              output logic [31:0] pa, output int cm);
        int nh = 0, hw = -1, hi = 0, hr = 0;
        int a;
        bit rd, wr, ex, ok;
        for (int w = 0; w < 6; w++) begin
            int idx = way_index(w, va);
            logic [31:0] msk = 32'hFFFF_FFFF << page_bits(w);
            int r = -1;
            for (int b = 3; b >= 0; b--)
                if (m_ring[8*b +: 8] == m_asid[w][idx]) r = b;
            if (m_va[w][idx] == (va & msk) && m_asid[w][idx] != 0 && r >= 0) begin
                nh++;
                if (hw < 0) begin hw = w; hi = idx; hr = r; end
            end
        end
        pa = 0; cm = 0;
        if (nh > 1)       cause = dside ? 4 : 3;
        else if (nh == 0) cause = dside ? 2 : 1;
        else if (hr < priv) cause = dside ? 6 : 5;
        else begin
            a  = int'(m_attr[hw][hi]);
            rd = (a < 12) || (a == 13);
            wr = ((a < 12) && a[1]) || (a == 13);
            ex = (a < 12) && a[0];
            ok = dside ? (st ? wr : rd) : ex;
            if (!ok) cause = dside ? (st ? 9 : 8) : 7;
            else begin
                cause = 0;
                pa = m_pa[hw][hi] | (va & ~(32'hFFFF_FFFF << page_bits(hw)));
                cm = (a == 13) ? 3 : (a >> 2);
            end
        end
    endtask

    task automatic compare(input string side, input string tag, input bit ev,
                           input logic v, input logic [3:0] c, input logic [31:0] p,
                           input logic [1:0] k, input int ec, input logic [31:0] ep,
                           input int ek);
        n_checks++;
        if (v !== ev || (ev && (int'(c) != ec || p !== ep || int'(k) != ek))) begin
            n_fail++;
            $display("FAIL %s %s: actual v=%0b cause=%0d pa=%h cache=%0d expected v=%0b cause=%0d pa=%h cache=%0d",
                     tag, side, v, c, p, k, ev, ec, ep, ek);
        end
    endtask

    // One clock: predict from pre-edge state, apply writes, compare both sides.
    task automatic tick(input string tag);
        bit v = req_valid;
        int cd = 0, cf = 0, kd = 0, kf = 0;
        logic [31:0] pd = 0, pf = 0;
        if (v) begin
            ref_lookup(1'b1, req_va, req_store, int'(req_priv), cd, pd, kd);
            ref_lookup(1'b0, req_va, req_store, int'(req_priv), cf, pf, kf);
        end
        if (ring_we) m_ring = ring_wdata;
        if (wr_en && wr_way < 6) begin
            int w = int'(wr_way);
            int e = (w < 4) ? int'(wr_idx) : int'(wr_idx[0]);
            logic [31:0] msk = 32'hFFFF_FFFF << page_bits(w);
            m_va[w][e] = wr_va & msk; m_pa[w][e] = wr_pa & msk;
            m_asid[w][e] = wr_asid;   m_attr[w][e] = wr_attr;
        end
        @(posedge clk);
        @(negedge clk);
        compare("data",  tag, v, d_valid, d_cause, d_pa, d_cache, cd, pd, kd);
        compare("fetch", tag, v, f_valid, f_cause, f_pa, f_cache, cf, pf, kf);
    endtask

    task automatic lookup(input logic [31:0] va, input bit st, input logic [1:0] pr,
                          input string tag);
        req_valid = 1'b1; req_va = va; req_store = st; req_priv = pr;
        tick(tag);
        req_valid = 1'b0;
    endtask

    task automatic write_entry(input logic [2:0] way, input logic [1:0] idx,
                               input logic [31:0] va, input logic [31:0] pa,
                               input logic [7:0] asid, input logic [3:0] attr,
                               input string tag);
        wr_en = 1'b1; wr_way = way; wr_idx = idx; wr_va = va; wr_pa = pa;
        wr_asid = asid; wr_attr = attr;
        tick(tag);
        wr_en = 1'b0;
    endtask

    task automatic set_ring(input logic [31:0] val, input string tag);
        ring_we = 1'b1; ring_wdata = val;
        tick(tag);
        ring_we = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : stimulus
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: response idle while in reset
        n_checks++;
        if (d_valid !== 1'b0 || f_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual v=%0b/%0b expected v=0/0", d_valid, f_valid);
        end
        rst_n = 1'b1;
        tick("R10 idle");

        // R1 preset fixed mappings, R9 offset, R7 cache codes
        lookup(32'hD000_1234, 1'b0, 2'd0, "R1 fixed A0");
        lookup(32'hD7FF_FFFF, 1'b1, 2'd0, "R9 fixed A0 top");
        lookup(32'hD800_0010, 1'b0, 2'd0, "R1 fixed A1");
        lookup(32'hE000_0100, 1'b1, 2'd0, "R1 fixed B0");
        lookup(32'hF000_00AB, 1'b0, 2'd0, "R1 fixed B1");
        lookup(32'h0000_0010, 1'b0, 2'd0, "R1 var asid zero");
        lookup(32'h0000_3000, 1'b0, 2'd0, "R4 miss");

        // R3 hit, index and page compare
        write_entry(3'd0, 2'd1, 32'h1234_5000, 32'hABCD_E000, 8'd1, 4'd7, "R11 fill");
        lookup(32'h1234_5678, 1'b0, 2'd0, "R3 hit");
        lookup(32'h1234_6678, 1'b0, 2'd0, "R3 other index");
        lookup(32'h2234_5678, 1'b0, 2'd0, "R3 page mismatch");

        // R2 ring mapping
        set_ring(32'h0908_0706, "R2 ring write");
        lookup(32'h1234_5678, 1'b0, 2'd0, "R2 asid absent");
        lookup(32'hD000_0000, 1'b0, 2'd0, "R2 fixed absent");
        set_ring(32'h0101_0203, "R2 ring dup");
        lookup(32'h1234_5678, 1'b0, 2'd2, "R2 lowest byte");
        lookup(32'h1234_5678, 1'b0, 2'd3, "R6 ring below priv");
        set_ring(32'h0403_0201, "R2 ring restore");

        // R6 privilege
        write_entry(3'd1, 2'd0, 32'h4000_0000, 32'h0800_0000, 8'd2, 4'd7, "R11 fill ring1");
        lookup(32'h4000_0ABC, 1'b1, 2'd1, "R6 equal ring");
        lookup(32'h4000_0ABC, 1'b1, 2'd2, "R6 priv fault");
        lookup(32'h4000_0ABC, 1'b0, 2'd0, "R6 more privileged");

        // R7/R8 every attribute, load and store on both sides
        for (int a = 0; a < 16; a++) begin
            write_entry(3'd1, 2'd3, 32'h0000_3000, 32'h7000_0000, 8'd4, 4'(a), "R11 attr fill");
            lookup(32'h0000_3ABC, 1'b0, 2'd3, "R7 load rights");
            lookup(32'h0000_3ABC, 1'b1, 2'd3, "R8 store rights");
        end

        // R11 ignored way and fixed-way index bit
        write_entry(3'd7, 2'd2, 32'h5555_6000, 32'h1111_1000, 8'd1, 4'd7, "R11 bad way");
        lookup(32'h5555_6000, 1'b0, 2'd0, "R11 bad way no effect");
        write_entry(3'd6, 2'd2, 32'h5555_6000, 32'h1111_1000, 8'd1, 4'd7, "R11 way6");
        lookup(32'h5555_6000, 1'b0, 2'd0, "R11 way6 no effect");
        write_entry(3'd4, 2'd3, 32'hD800_0000, 32'h2000_0000, 8'd1, 4'd4, "R11 fixed rewrite");
        lookup(32'hD800_0044, 1'b1, 2'd0, "R11 fixed idx bit0");

        // R10 write and lookup in the same cycle
        req_valid = 1'b1; req_va = 32'h1234_5678; req_store = 1'b0; req_priv = 2'd0;
        wr_en = 1'b1; wr_way = 3'd0; wr_idx = 2'd1; wr_va = 32'h1234_5000;
        wr_pa = 32'h6666_6000; wr_asid = 8'd1; wr_attr = 4'd5;
        tick("R10 lookup sees old");
        wr_en = 1'b0;
        tick("R10 back to back new");
        req_valid = 1'b0;
        tick("R10 idle after");

        // R5 multi-hit
        write_entry(3'd2, 2'd1, 32'h1234_5000, 32'h3000_0000, 8'd3, 4'd7, "R11 dup fill");
        lookup(32'h1234_5678, 1'b0, 2'd0, "R5 two var ways");
        lookup(32'h1234_5678, 1'b0, 2'd3, "R5 over priv");
        write_entry(3'd3, 2'd0, 32'hD000_0000, 32'h0, 8'd1, 4'd7, "R11 overlap fixed");
        lookup(32'hD000_0000, 1'b1, 2'd0, "R5 var and fixed");
        lookup(32'hE000_0000, 1'b0, 2'd0, "R9 untouched fixed");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule